// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block drives a successive-approximation converter from the digital side. It divides the system clock into a converter clock and times a sample phase followed by a conversion phase. The conversion phase is as long as the selected resolution needs. When the conversion phase ends, the block takes the analog front end's raw value, trims it to the resolution, and presents it for one cycle together with the group and channel that produced it. A small file of channel-group registers holds one channel number and one completion-interrupt enable per group.

Conversions start in one of two ways. In software mode, a write to group 0 starts a conversion. In hardware mode, a trigger pulse starts a conversion, and successive triggers use the groups in rotation. A continuous option restarts the conversion after each completion. A write to the group that is converting cancels the conversion in progress. The timing configuration is taken at each start, so changes made during a conversion do not affect it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The sample phase (`smp_phase` high) lasts S converter clocks, measured from the start. With `cfg_long`=0, S is 2, 4, 6 or 8 for `cfg_smp` codes 0 to 3. With `cfg_long`=1, S is 12, 16, 20 or 24 for the same codes.
- R2: One converter clock is N system clocks, where N is 1, 2, 4 or 8 for `cfg_div` codes 0 to 3.
- R3: `cfg_res` codes 0, 1 and 2 give B = 8, 10 and 12 bits, and code 3 also gives 12. The conversion phase lasts B+2 converter clocks, so `busy` stays high for (S+B+2)·N clocks. `done_data` equals `afe_result` shifted right by 12−B.
- R4: `busy` rises on the clock edge that accepts a start and falls on the edge where `done` rises. `done` is a one-cycle pulse. During that pulse, `done_grp` and `done_chan` give the group and its channel, and `done_irq` copies that group's interrupt enable.
- R5: In software mode (`cfg_hw_mode`=0), a write to group 0 starts a conversion. Writes to groups 1 and above never start one, and `hw_trig` is ignored.
- R6: In hardware mode, group writes never start a conversion. Each accepted `hw_trig` starts a conversion on groups 0, 1, …, G−1 in turn and then wraps to 0.
- R7: A write to the group that is converting aborts the conversion: `busy` falls on the next edge and no `done` is produced. In software mode, such a write to group 0 also starts a new conversion with the new channel, and the full timing begins again.
- R8: A write to any other group while a conversion runs leaves that conversion's length, group and result unchanged.
- R9: A `hw_trig` that arrives while `busy` is high is ignored and does not advance the rotation.
- R10: With `cfg_cont`=1 at completion, `done` pulses, `busy` stays high and the same group starts again, with one completion every (S+B+2)·N clocks. Clearing `cfg_cont` lets the next completion end the run.
- R11: `cfg_div`, `cfg_smp`, `cfg_long` and `cfg_res` are captured at each start. Changing them mid-conversion does not alter that conversion.
- R12: After reset, `busy`, `done` and `smp_phase` are low, the hardware rotation points at group 0, and every group holds channel 0 with its interrupt enable cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 2 | Converter clock divide code |
| cfg_smp | input | 2 | Sample length code |
| cfg_long | input | 1 | Long-sample select |
| cfg_res | input | 2 | Resolution code |
| cfg_hw_mode | input | 1 | 1 = hardware triggers, 0 = software start |
| cfg_cont | input | 1 | Continuous conversion enable |
| grp_wr | input | 1 | Group register write strobe |
| grp_wr_sel | input | SEL_W | Group being written |
| grp_wr_chan | input | CHAN_W | Channel number written |
| grp_wr_ie | input | 1 | Interrupt enable written |
| hw_trig | input | 1 | Hardware trigger pulse |
| afe_result | input | 12 | Raw value from the analog front end |
| busy | output | 1 | Conversion active, from sample start to hand-off |
| smp_phase | output | 1 | Sample phase in progress |
| done | output | 1 | One-cycle completion pulse |
| done_grp | output | SEL_W | Group of the completed conversion |
| done_chan | output | CHAN_W | Channel of the completed conversion |
| done_data | output | 12 | Right-justified result |
| done_irq | output | 1 | Completion interrupt request |

## Verification
The main test covers every combination of divide code, sample code, long/short mode and resolution code. It measures the sample-phase length and the busy length separately, so an error in the divider, the sample table or the per-resolution bit count shows up as its own mismatch. Each conversion in that test uses a different front-end value, so the check on the result shift is independent of the timing checks. Directed runs then start a side event at a fixed cycle inside a conversion and read the effect from the busy length and the completion fields. The side events are a self-write, a write to another group, a trigger while busy, and a configuration change. These runs separate an abort, an abort followed by a restart, a write that must leave the conversion alone, and a trigger that must be ignored. A continuous run checks the spacing between completions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_MAX = 12;   // widest result
    localparam int CNT_W   = 6;    // holds the longest phase count (24+12+2)
    localparam int DIV_W   = 3;    // holds the largest divide limit (7)
    localparam int BITS_W  = 5;

    typedef struct packed {
        logic [DIV_W-1:0]  div_lim;
        logic [CNT_W-1:0]  smp_len;
        logic [CNT_W-1:0]  tot_len;
        logic [BITS_W-1:0] res_bits;
    } conv_cfg_t;

    function automatic logic [CNT_W-1:0] smp_clocks(input logic [1:0] code,
                                                     input logic long_mode);
        logic [CNT_W-1:0] c;
        c = CNT_W'(code);
        if (long_mode) return CNT_W'(12) + (c << 2);
        return (c << 1) + CNT_W'(2);
    endfunction

    function automatic logic [BITS_W-1:0] res_width(input logic [1:0] code);
        case (code)
            2'd0:    return BITS_W'(8);
            2'd1:    return BITS_W'(10);
            default: return BITS_W'(RES_MAX);
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] div_limit(input logic [1:0] code);
        case (code)
            2'd0:    return DIV_W'(0);
            2'd1:    return DIV_W'(1);
            2'd2:    return DIV_W'(3);
            default: return DIV_W'(7);
        endcase
    endfunction

    function automatic conv_cfg_t make_cfg(input logic [1:0] div_code,
                                           input logic [1:0] smp_code,
                                           input logic       long_mode,
                                           input logic [1:0] res_code);
        conv_cfg_t c;
        c.div_lim  = div_limit(div_code);
        c.smp_len  = smp_clocks(smp_code, long_mode);
        c.res_bits = res_width(res_code);
        c.tot_len  = c.smp_len + CNT_W'(c.res_bits) + CNT_W'(2);
        return c;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic [W-1:0] lim,
    output logic         tick
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start || !en)      cnt_d = '0;
        else if (cnt_q == lim) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == lim);

    // R2: with a divide above one, two converter clocks never fall on adjacent cycles
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !start && (lim != '0) |=> !tick);

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic         tick,
    input  logic [W-1:0] smp_len,
    input  logic [W-1:0] tot_len,
    output logic         smp_phase,
    output logic         fin
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start || !en) cnt_d = '0;
        else if (tick)    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign smp_phase = en && (cnt_q < smp_len);
    assign fin       = en && tick && (cnt_q == tot_len - 1'b1);

    // R1: once the conversion phase begins, sampling only resumes after a new start
    assert_no_resample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en && !start && !smp_phase |=> !smp_phase);

endmodule

// File: rtl/adc_grp_regs.sv
module adc_grp_regs #(
    parameter int NUM_GRP = 4,
    parameter int CHAN_W  = 5,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              wr_ie,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CHAN_W-1:0] rd_chan,
    output logic              rd_ie
);

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              ie;
    } grp_t;

    grp_t regs_d [NUM_GRP];
    grp_t regs_q [NUM_GRP];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr && (wr_sel == SEL_W'(g))) begin
                regs_d[g].chan = wr_chan;
                regs_d[g].ie   = wr_ie;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end
    end

    assign rd_chan = regs_q[rd_sel].chan;
    assign rd_ie   = regs_q[rd_sel].ie;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int CHAN_W  = 5,
    localparam int SEL_W  = $clog2(NUM_GRP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_div,
    input  logic [1:0]         cfg_smp,
    input  logic               cfg_long,
    input  logic [1:0]         cfg_res,
    input  logic               cfg_hw_mode,
    input  logic               cfg_cont,
    input  logic               grp_wr,
    input  logic [SEL_W-1:0]   grp_wr_sel,
    input  logic [CHAN_W-1:0]  grp_wr_chan,
    input  logic               grp_wr_ie,
    input  logic               hw_trig,
    input  logic [RES_MAX-1:0] afe_result,
    output logic               busy,
    output logic               smp_phase,
    output logic               done,
    output logic [SEL_W-1:0]   done_grp,
    output logic [CHAN_W-1:0]  done_chan,
    output logic [RES_MAX-1:0] done_data,
    output logic               done_irq
);

    typedef struct packed {
        logic               busy;
        logic [SEL_W-1:0]   grp;
        logic [SEL_W-1:0]   ptr;
        conv_cfg_t          cfg;
        logic               done;
        logic [SEL_W-1:0]   done_grp;
        logic [CHAN_W-1:0]  done_chan;
        logic               done_ie;
        logic [RES_MAX-1:0] done_data;
    } st_t;

    st_t st_d, st_q;

    logic              tick, fin, start;
    logic              abort, sw_start, hw_start, restart;
    logic [CHAN_W-1:0] cur_chan;
    logic              cur_ie;
    logic [BITS_W-1:0] shamt;

    adc_grp_regs #(.NUM_GRP(NUM_GRP), .CHAN_W(CHAN_W), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (grp_wr),
        .wr_sel  (grp_wr_sel),
        .wr_chan (grp_wr_chan),
        .wr_ie   (grp_wr_ie),
        .rd_sel  (st_q.grp),
        .rd_chan (cur_chan),
        .rd_ie   (cur_ie)
    );

    adc_clk_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.busy),
        .start (start),
        .lim   (st_q.cfg.div_lim),
        .tick  (tick)
    );

    adc_phase_timer #(.W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (st_q.busy),
        .start     (start),
        .tick      (tick),
        .smp_len   (st_q.cfg.smp_len),
        .tot_len   (st_q.cfg.tot_len),
        .smp_phase (smp_phase),
        .fin       (fin)
    );

    always_comb begin
        abort    = st_q.busy && grp_wr && (grp_wr_sel == st_q.grp);
        sw_start = !cfg_hw_mode && grp_wr && (grp_wr_sel == '0);
        hw_start = cfg_hw_mode && hw_trig && !st_q.busy;
        restart  = st_q.busy && fin && cfg_cont && !abort;
        start    = sw_start || hw_start || restart;
        shamt    = BITS_W'(RES_MAX) - st_q.cfg.res_bits;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (st_q.busy && fin && !abort) begin
            st_d.done      = 1'b1;
            st_d.done_grp  = st_q.grp;
            st_d.done_chan = cur_chan;
            st_d.done_ie   = cur_ie;
            st_d.done_data = afe_result >> shamt;
            st_d.busy      = cfg_cont;
        end

        if (abort) st_d.busy = 1'b0;

        if (sw_start) begin
            st_d.busy = 1'b1;
            st_d.grp  = '0;
        end else if (hw_start) begin
            st_d.busy = 1'b1;
            st_d.grp  = st_q.ptr;
            st_d.ptr  = (st_q.ptr == SEL_W'(NUM_GRP - 1)) ? '0 : st_q.ptr + 1'b1;
        end

        if (start) st_d.cfg = make_cfg(cfg_div, cfg_smp, cfg_long, cfg_res);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign done_grp  = st_q.done_grp;
    assign done_chan = st_q.done_chan;
    assign done_data = st_q.done_data;
    assign done_irq  = st_q.done && st_q.done_ie;

    // R5: software mode, idle, write to a nonzero group leaves the block idle
    assert_sw_other_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !cfg_hw_mode && grp_wr && (grp_wr_sel != '0) && !hw_trig |=> !busy);

    // R7: hardware mode, write to the active group cancels without completion
    assert_abort_hw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_hw_mode && grp_wr && (grp_wr_sel == st_q.grp) |=> !busy && !done);

    // R8: a write to another group leaves the running conversion in place
    assert_other_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && grp_wr && (grp_wr_sel != st_q.grp) && !fin |=> busy && $stable(st_q.grp));

    // R9: a trigger while busy neither moves the rotation nor the active group
    assert_hw_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_hw_mode && hw_trig && !grp_wr && !fin
        |=> busy && $stable(st_q.grp) && $stable(st_q.ptr));

    // R10: at completion, busy continues exactly when continuous mode was on
    assert_cont_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy == $past(cfg_cont)));

    // R4: completion is a single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int NG = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_div, cfg_smp, cfg_res;
    logic        cfg_long, cfg_hw_mode, cfg_cont;
    logic        grp_wr;
    logic [1:0]  grp_wr_sel;
    logic [4:0]  grp_wr_chan;
    logic        grp_wr_ie;
    logic        hw_trig;
    logic [11:0] afe_result;
    logic        busy, smp_phase, done, done_irq;
    logic [1:0]  done_grp;
    logic [4:0]  done_chan;
    logic [11:0] done_data;

    int checks = 0;
    int errors = 0;
    int smp_seen;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.NUM_GRP(NG), .CHAN_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_smp(cfg_smp),
        .cfg_long(cfg_long), .cfg_res(cfg_res), .cfg_hw_mode(cfg_hw_mode),
        .cfg_cont(cfg_cont), .grp_wr(grp_wr), .grp_wr_sel(grp_wr_sel),
        .grp_wr_chan(grp_wr_chan), .grp_wr_ie(grp_wr_ie), .hw_trig(hw_trig),
        .afe_result(afe_result), .busy(busy), .smp_phase(smp_phase),
        .done(done), .done_grp(done_grp), .done_chan(done_chan),
        .done_data(done_data), .done_irq(done_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        grp_wr = 0; grp_wr_sel = 0; grp_wr_chan = 0; grp_wr_ie = 0; hw_trig = 0;
        cfg_div = 0; cfg_smp = 0; cfg_long = 0; cfg_res = 0;
        cfg_hw_mode = 0; cfg_cont = 0; afe_result = 12'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic sw_write(input int sel, input int chan, input bit ie);
        grp_wr = 1; grp_wr_sel = 2'(sel); grp_wr_chan = 5'(chan); grp_wr_ie = ie;
        @(negedge clk);
        grp_wr = 0;
    endtask

    task automatic hw_pulse();
        hw_trig = 1;
        @(negedge clk);
        hw_trig = 0;
    endtask

    // Counts busy negedges; at count 'at' drives a side stimulus for one cycle
    task automatic busy_run(input int at, input int kind, input int sel,
                            input int chan, output int total);
        total = 0;
        smp_seen = 0;
        while (busy && total < 3000) begin
            total++;
            if (smp_phase) smp_seen++;
            if (total == at) begin
                if (kind == 1) begin
                    grp_wr = 1; grp_wr_sel = 2'(sel); grp_wr_chan = 5'(chan); grp_wr_ie = 0;
                end else if (kind == 2) begin
                    hw_trig = 1;
                end
            end
            @(negedge clk);
            grp_wr = 0;
            hw_trig = 0;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int tot;
        int idx;
        do_reset();

        // R12: reset state
        chk(!busy && !done && !smp_phase, "R12 reset outputs", int'(busy), 0);

        // Sweep: R1 R2 R3 R4
        idx = 0;
        for (int dv = 0; dv < 4; dv++)
            for (int sc = 0; sc < 4; sc++)
                for (int lg = 0; lg < 2; lg++)
                    for (int rs = 0; rs < 4; rs++) begin
                        int n, s, b, exp_data, ch;
                        n  = 1 << dv;
                        s  = lg ? 12 + 4 * sc : 2 + 2 * sc;
                        b  = (rs == 0) ? 8 : (rs == 1) ? 10 : 12;
                        ch = idx % 32;
                        cfg_div = 2'(dv); cfg_smp = 2'(sc); cfg_long = lg[0]; cfg_res = 2'(rs);
                        afe_result = 12'((idx * 37 + 1443) % 4096);
                        exp_data = int'(afe_result) >> (12 - b);
                        sw_write(0, ch, idx[0]);
                        busy_run(0, 0, 0, 0, tot);
                        chk(smp_seen == s * n, "R1 sample length", smp_seen, s * n);
                        chk(tot == (s + b + 2) * n, "R3 busy length", tot, (s + b + 2) * n);
                        chk(done && int'(done_data) == exp_data, "R3 result", int'(done_data), exp_data);
                        chk(int'(done_chan) == ch && done_grp == 0 && done_irq == idx[0],
                            "R4 done fields", int'(done_chan), ch);
                        @(negedge clk);
                        chk(!done, "R4 single pulse", int'(done), 0);
                        idx++;
                    end

        // R2 direct: divide by 8 with fixed shortest config
        cfg_div = 3; cfg_smp = 0; cfg_long = 0; cfg_res = 0;
        sw_write(0, 1, 0);
        busy_run(0, 0, 0, 0, tot);
        chk(tot == 96, "R2 divide by eight", tot, 96);
        @(negedge clk);

        // Fixed short config for directed tests: T = 12 clocks
        cfg_div = 0; cfg_smp = 0; cfg_long = 0; cfg_res = 0;

        // R5: nonzero group write and hw_trig do not start in software mode
        sw_write(1, 5, 1);
        chk(!busy, "R5 group1 write no start", int'(busy), 0);
        repeat (2) @(negedge clk);
        chk(!busy, "R5 still idle", int'(busy), 0);
        hw_pulse();
        chk(!busy, "R5 hw_trig ignored in sw mode", int'(busy), 0);

        // R7: software self-write aborts and restarts
        sw_write(0, 3, 0);
        busy_run(5, 1, 0, 9, tot);
        chk(tot == 17, "R7 sw abort restart length", tot, 17);
        chk(done && done_chan == 9, "R7 restart channel", int'(done_chan), 9);
        @(negedge clk);

        // R11: configuration change mid-conversion has no effect
        sw_write(0, 2, 0);
        cfg_div = 3; cfg_res = 2;
        busy_run(0, 0, 0, 0, tot);
        chk(tot == 12, "R11 latched config", tot, 12);
        cfg_div = 0; cfg_res = 0;
        @(negedge clk);

        // Hardware mode: R6 R12 R4
        do_reset();
        cfg_hw_mode = 1;
        sw_write(2, 21, 1);
        chk(!busy, "R6 write no start in hw mode", int'(busy), 0);
        sw_write(0, 0, 0);
        chk(!busy, "R6 group0 write no start in hw mode", int'(busy), 0);
        for (int k = 0; k < 5; k++) begin
            hw_pulse();
            busy_run(0, 0, 0, 0, tot);
            chk(tot == 12, "R6 hw conversion length", tot, 12);
            chk(done && int'(done_grp) == k % NG, "R6 rotation group", int'(done_grp), k % NG);
            if (k == 0) chk(done_chan == 0 && !done_irq, "R12 group reset value", int'(done_chan), 0);
            if (k == 2) chk(done_chan == 21 && done_irq, "R4 irq from group", int'(done_irq), 1);
            @(negedge clk);
        end

        // R9: trigger while busy is ignored
        hw_pulse();
        busy_run(3, 2, 0, 0, tot);
        chk(tot == 12, "R9 busy trigger no effect", tot, 12);
        chk(done_grp == 1, "R9 group", int'(done_grp), 1);
        @(negedge clk);
        hw_pulse();
        busy_run(0, 0, 0, 0, tot);
        chk(done_grp == 2, "R9 rotation not advanced", int'(done_grp), 2);
        @(negedge clk);

        // R8: write to another group during a conversion
        hw_pulse();
        busy_run(3, 1, 1, 17, tot);
        chk(tot == 12, "R8 other write length", tot, 12);
        chk(done && done_grp == 3 && done_chan == 0, "R8 other write fields", int'(done_grp), 3);
        @(negedge clk);

        // R7: hardware abort
        hw_pulse();
        busy_run(4, 1, 0, 6, tot);
        chk(tot == 4 && !done, "R7 hw abort", tot, 4);
        begin
            int seen;
            seen = 0;
            repeat (15) begin
                @(negedge clk);
                if (done || busy) seen++;
            end
            chk(seen == 0, "R7 no completion after abort", seen, 0);
        end

        // R10: continuous mode
        do_reset();
        cfg_cont = 1;
        sw_write(0, 4, 1);
        begin
            int last;
            last = -1;
            for (int i = 1; i <= 60; i++) begin
                if (done) begin
                    if (last >= 0) chk(i - last == 12, "R10 completion spacing", i - last, 12);
                    chk(busy && done_grp == 0, "R10 busy through completion", int'(busy), 1);
                    last = i;
                end
                @(negedge clk);
            end
            cfg_cont = 0;
            for (int i = 0; i < 30 && !(done && !busy); i++) @(negedge clk);
            chk(done && !busy && done_chan == 4 && done_irq, "R10 run ends", int'(busy), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule